// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block is the interrupt presentation point for a single processor. It holds a current priority threshold, an inter-processor request priority and one latched external request. It raises a line to the CPU whenever a held request is more favoured than the threshold, where a numerically lower priority is more favoured. Software reads an accept word to take the winning interrupt. The read returns the threshold as it was before the read, together with the winning vector. In the same cycle the threshold drops to the winner's priority.

When handling is done, software writes an end-of-interrupt word that carries the threshold to restore. One cycle later the block reports whether another request already beats that restored threshold, so software knows to read again. Inter-processor requests are raised and cancelled through their own priority register and are presented under a fixed reserved vector. An empty accept returns a reserved spurious vector.

Top module: `irq_present_unit`

## Requirements
- R1: `cpu_irq` is high in the same cycle whenever the inter-processor request or the latched external request has a priority strictly below the threshold; a priority equal to the threshold is not presented.
- R2: After reset the threshold is 0x00, the inter-processor priority is 0xFF, no external request is held, and `cpu_irq` and `eoi_more` are low. A threshold of 0x00 blocks every request, and 0xFF admits any priority below 0xFF.
- R3: Register select 0 is the accept/EOI word, with the threshold in bits 31:24 and the vector in bits 23:0. Select 1 is the threshold and select 2 the inter-processor priority, each in bits 7:0 and read back zero-extended. Select 3 reads as zero and ignores writes. Reads of selects 1 to 3 change nothing.
- R4: An accept read (`reg_rd` with select 0) with a presentable request returns {old threshold, winner vector}. At that clock edge the threshold becomes the winner's priority, and if the external request won its slot is emptied.
- R5: An accept read with nothing presentable returns {threshold, 0x000000} (vector 0 is spurious) and leaves the threshold unchanged.
- R6: Writing an inter-processor priority below 0xFF raises that request at that priority, presented with vector 0x000002. Writing 0xFF cancels it.
- R7: When both requests are presentable, the lower priority value wins; on equal priority the inter-processor request wins.
- R8: Neither accepting the inter-processor request nor an EOI naming vector 2 changes the inter-processor priority.
- R9: An EOI write sets the threshold to bits 31:24. In the following cycle `eoi_more` is high exactly when a request held before that edge has a priority below the new threshold; otherwise `eoi_more` is low.
- R10: An external request is latched when `ext_valid` is high and the slot is empty. It is ignored while the slot is full, and it is dropped if its vector is 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe; on select 0 it accepts the presented interrupt |
| reg_wr | input | 1 | Write strobe; takes precedence over `reg_rd` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| eoi_more | output | 1 | Pulse one cycle after an EOI write: further work is pending |
| ext_valid | input | 1 | External request strobe |
| ext_vec | input | 24 | External request vector |
| ext_prio | input | 8 | External request priority |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The threshold comparison is exercised with an external request at exactly the threshold, one above it and one below it, and at both extreme thresholds. Together these tell strict from non-strict comparison and show blocking and admitting behaviour. Arbitration is tried with equal priorities, where the inter-processor request must win, and with the external request more favoured, which tells the tie rule from the ordering rule. EOI writes restore thresholds equal to and just above a pending priority, which separates a correct `eoi_more` from one computed with the wrong comparison. Writes to a full slot and requests with reserved vectors show that dropped requests never reach the line.

// File: rtl/ipu_pkg.sv
`timescale 1ns/1ps
package ipu_pkg;
  localparam int unsigned DEF_VEC_W  = 24;
  localparam int unsigned DEF_PRIO_W = 8;
  localparam int unsigned DEF_SPUR   = 0;
  localparam int unsigned DEF_IPI    = 2;

  typedef enum logic [1:0] {
    SEL_WORD = 2'd0,
    SEL_THR  = 2'd1,
    SEL_IPIP = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ipu_ext_slot.sv
`timescale 1ns/1ps
module ipu_ext_slot #(
  parameter int unsigned VEC_W    = 24,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned SPUR_VEC = 0,
  parameter int unsigned IPI_VEC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              take,
  output logic              full,
  output logic [VEC_W-1:0]  vec,
  output logic [PRIO_W-1:0] prio
);
  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] IPI_V  = VEC_W'(IPI_VEC);

  logic              full_q, full_d;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] prio_q;
  logic              reserved, load_en;

  // Reserved vectors never enter the slot.
  assign reserved = (req_vec == SPUR_V) || (req_vec == IPI_V);
  assign load_en  = req_vld && !full_q && !reserved;

  always_comb begin
    full_d = full_q;
    if (take)         full_d = 1'b0;
    else if (load_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      prio_q <= '1;
    end else if (load_en) begin
      vec_q  <= req_vec;
      prio_q <= req_prio;
    end
  end

  assign full = full_q;
  assign vec  = vec_q;
  assign prio = prio_q;
endmodule

// File: rtl/ipu_arbiter.sv
`timescale 1ns/1ps
module ipu_arbiter #(
  parameter int unsigned VEC_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_VEC = 2
) (
  input  logic [PRIO_W-1:0] thr,
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic              ext_full,
  input  logic [VEC_W-1:0]  ext_vec,
  input  logic [PRIO_W-1:0] ext_prio,
  output logic              win_vld,
  output logic              win_ipi,
  output logic [VEC_W-1:0]  win_vec,
  output logic [PRIO_W-1:0] win_prio
);
  localparam logic [PRIO_W-1:0] IDLE_P = '1;

  logic ipi_ok, ext_ok;

  assign ipi_ok  = (ipi_prio != IDLE_P) && (ipi_prio < thr);
  assign ext_ok  = ext_full && (ext_prio < thr);
  // Tie goes to the inter-processor request.
  assign win_ipi = ipi_ok && (!ext_ok || (ipi_prio <= ext_prio));
  assign win_vld = ipi_ok || ext_ok;

  always_comb begin
    if (win_ipi) begin
      win_vec  = VEC_W'(IPI_VEC);
      win_prio = ipi_prio;
    end else begin
      win_vec  = ext_vec;
      win_prio = ext_prio;
    end
  end
endmodule

// File: rtl/ipu_prio_regs.sv
`timescale 1ns/1ps
module ipu_prio_regs #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_ld,
  input  logic [PRIO_W-1:0] thr_val,
  input  logic              ipi_ld,
  input  logic [PRIO_W-1:0] ipi_val,
  input  logic              more_d,
  output logic [PRIO_W-1:0] thr,
  output logic [PRIO_W-1:0] ipi_prio,
  output logic              more
);
  logic [PRIO_W-1:0] thr_q, thr_d, ipi_q, ipi_d;
  logic              more_q;

  always_comb begin
    thr_d = thr_q;
    ipi_d = ipi_q;
    if (thr_ld) thr_d = thr_val;
    if (ipi_ld) ipi_d = ipi_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      ipi_q  <= '1;
      more_q <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      ipi_q  <= ipi_d;
      more_q <= more_d;
    end
  end

  assign thr      = thr_q;
  assign ipi_prio = ipi_q;
  assign more     = more_q;
endmodule

// File: rtl/irq_present_unit.sv
`timescale 1ns/1ps
module irq_present_unit
  import ipu_pkg::*;
#(
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned PRIO_W   = DEF_PRIO_W,
  parameter int unsigned SPUR_VEC = DEF_SPUR,
  parameter int unsigned IPI_VEC  = DEF_IPI
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                reg_sel,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic [PRIO_W+VEC_W-1:0]   reg_wdata,
  output logic [PRIO_W+VEC_W-1:0]   reg_rdata,
  output logic                      eoi_more,
  input  logic                      ext_valid,
  input  logic [VEC_W-1:0]          ext_vec,
  input  logic [PRIO_W-1:0]         ext_prio,
  output logic                      cpu_irq
);
  localparam int unsigned WORD_W = PRIO_W + VEC_W;

  reg_sel_e          sel;
  logic              rd_acc, wr_eoi, wr_thr, wr_ipi, take, ext_take;
  logic [PRIO_W-1:0] cppr_q, mfrr_q, thr_val, eoi_thr;
  logic              ext_full;
  logic [VEC_W-1:0]  ext_vec_q, win_vec;
  logic [PRIO_W-1:0] ext_prio_q, win_prio;
  logic              win_vld, win_ipi;
  logic              la_vld;
  logic              unused_la_ipi;
  logic [VEC_W-1:0]  unused_la_vec;
  logic [PRIO_W-1:0] unused_la_prio;
  logic              unused_wd;

  assign sel      = reg_sel_e'(reg_sel);
  assign wr_eoi   = reg_wr && (sel == SEL_WORD);
  assign wr_thr   = reg_wr && (sel == SEL_THR);
  assign wr_ipi   = reg_wr && (sel == SEL_IPIP);
  assign rd_acc   = reg_rd && !reg_wr && (sel == SEL_WORD);
  assign take     = rd_acc && win_vld;
  assign ext_take = take && !win_ipi;
  assign eoi_thr  = reg_wdata[WORD_W-1:VEC_W];

  always_comb begin
    if (wr_eoi)      thr_val = eoi_thr;
    else if (wr_thr) thr_val = reg_wdata[PRIO_W-1:0];
    else             thr_val = win_prio;
  end

  ipu_ext_slot #(
    .VEC_W(VEC_W), .PRIO_W(PRIO_W), .SPUR_VEC(SPUR_VEC), .IPI_VEC(IPI_VEC)
  ) u_slot (
    .clk(clk), .rst_n(rst_n),
    .req_vld(ext_valid), .req_vec(ext_vec), .req_prio(ext_prio),
    .take(ext_take),
    .full(ext_full), .vec(ext_vec_q), .prio(ext_prio_q)
  );

  ipu_prio_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .thr_ld(wr_eoi || wr_thr || take), .thr_val(thr_val),
    .ipi_ld(wr_ipi), .ipi_val(reg_wdata[PRIO_W-1:0]),
    .more_d(wr_eoi && la_vld),
    .thr(cppr_q), .ipi_prio(mfrr_q), .more(eoi_more)
  );

  // Presentation against the live threshold.
  ipu_arbiter #(.VEC_W(VEC_W), .PRIO_W(PRIO_W), .IPI_VEC(IPI_VEC)) u_arb (
    .thr(cppr_q), .ipi_prio(mfrr_q),
    .ext_full(ext_full), .ext_vec(ext_vec_q), .ext_prio(ext_prio_q),
    .win_vld(win_vld), .win_ipi(win_ipi), .win_vec(win_vec), .win_prio(win_prio)
  );

  // Look-ahead against the threshold an EOI is about to restore.
  ipu_arbiter #(.VEC_W(VEC_W), .PRIO_W(PRIO_W), .IPI_VEC(IPI_VEC)) u_look (
    .thr(eoi_thr), .ipi_prio(mfrr_q),
    .ext_full(ext_full), .ext_vec(ext_vec_q), .ext_prio(ext_prio_q),
    .win_vld(la_vld), .win_ipi(unused_la_ipi), .win_vec(unused_la_vec),
    .win_prio(unused_la_prio)
  );

  always_comb begin
    unique case (sel)
      SEL_WORD: reg_rdata = {cppr_q, (win_vld ? win_vec : VEC_W'(SPUR_VEC))};
      SEL_THR:  reg_rdata = WORD_W'(cppr_q);
      SEL_IPIP: reg_rdata = WORD_W'(mfrr_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign cpu_irq   = win_vld;
  assign unused_wd = ^reg_wdata[VEC_W-1:PRIO_W];
endmodule

// File: rtl/ipu_checker.sv
`timescale 1ns/1ps
module ipu_checker #(
  parameter int unsigned VEC_W    = 24,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned SPUR_VEC = 0,
  parameter int unsigned IPI_VEC  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              reg_sel,
  input logic                    reg_rd,
  input logic                    reg_wr,
  input logic [PRIO_W+VEC_W-1:0] reg_wdata,
  input logic [PRIO_W+VEC_W-1:0] reg_rdata,
  input logic                    cpu_irq,
  input logic [PRIO_W-1:0]       cppr_q,
  input logic [PRIO_W-1:0]       mfrr_q,
  input logic                    ext_full,
  input logic [VEC_W-1:0]        ext_vec_q
);
  localparam int unsigned WORD_W = PRIO_W + VEC_W;
  logic acc;
  assign acc = reg_rd && !reg_wr && (reg_sel == 2'd0);

  p_zero_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_q == '0) |-> !cpu_irq);

  p_spurious_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cpu_irq) |-> (reg_rdata[VEC_W-1:0] == VEC_W'(SPUR_VEC)));

  p_accept_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpu_irq) |=> (cppr_q < $past(reg_rdata[WORD_W-1:VEC_W])));

  p_eoi_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (cppr_q == $past(reg_wdata[WORD_W-1:VEC_W])));

  p_no_ipi_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpu_irq && mfrr_q == '1) |-> (reg_rdata[VEC_W-1:0] != VEC_W'(IPI_VEC)));

  p_ipi_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_sel == 2'd2)) |=> $stable(mfrr_q));

  p_slot_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_full && !(acc && cpu_irq && reg_rdata[VEC_W-1:0] != VEC_W'(IPI_VEC)))
      |=> (ext_full && $stable(ext_vec_q)));
endmodule

bind irq_present_unit ipu_checker #(
  .VEC_W(VEC_W), .PRIO_W(PRIO_W), .SPUR_VEC(SPUR_VEC), .IPI_VEC(IPI_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq),
  .cppr_q(cppr_q), .mfrr_q(mfrr_q), .ext_full(ext_full), .ext_vec_q(ext_vec_q)
);

// File: tb/tb_irq_present_unit.sv
`timescale 1ns/1ps
module tb_irq_present_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eoi_more, cpu_irq;
  logic        ext_valid = 1'b0;
  logic [23:0] ext_vec = '0;
  logic [7:0]  ext_prio = '0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] w;

  always #4 clk = ~clk;

  irq_present_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eoi_more(eoi_more),
    .ext_valid(ext_valid), .ext_vec(ext_vec), .ext_prio(ext_prio), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic accept(output logic [31:0] word);
    @(negedge clk); reg_sel = 2'd0; reg_rd = 1'b1;
    #2 word = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [31:0] word);
    @(negedge clk); reg_sel = s;
    #1 word = reg_rdata;
  endtask

  task automatic push(input logic [23:0] v, input logic [7:0] p);
    @(negedge clk); ext_valid = 1'b1; ext_vec = v; ext_prio = p;
    @(negedge clk); ext_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R2 irq after reset", 32'(cpu_irq), 32'd0);
    chk("R2 more after reset", 32'(eoi_more), 32'd0);
    peek(2'd1, w); chk("R2 threshold reset", w, 32'h0);
    peek(2'd2, w); chk("R2 ipi prio reset", w, 32'hff);
    accept(w);     chk("R5 empty accept", w, 32'h0000_0000);
    peek(2'd1, w); chk("R5 threshold unchanged", w, 32'h0);
  endtask

  task automatic t_threshold;
    wr(2'd1, 32'h05);
    push(24'h123456, 8'd5);
    chk("R1 equal priority not presented", 32'(cpu_irq), 32'd0);
    wr(2'd1, 32'h06);
    chk("R1 lower priority presented", 32'(cpu_irq), 32'd1);
    wr(2'd1, 32'h00);
    chk("R2 zero threshold blocks", 32'(cpu_irq), 32'd0);
    wr(2'd1, 32'hff);
    chk("R2 ff threshold admits", 32'(cpu_irq), 32'd1);
    accept(w);     chk("R4 accept word", w, 32'hff12_3456);
    peek(2'd1, w); chk("R4 threshold takes winner prio", w, 32'h05);
    chk("R4 slot emptied", 32'(cpu_irq), 32'd0);
    wr(2'd1, 32'hff);
    chk("R4 slot empty at open threshold", 32'(cpu_irq), 32'd0);
    wr(2'd1, 32'h05);
    accept(w);     chk("R5 spurious accept", w, 32'h0500_0000);
  endtask

  task automatic t_ipi;
    wr(2'd1, 32'hff);
    wr(2'd2, 32'h03);
    chk("R6 ipi raised", 32'(cpu_irq), 32'd1);
    accept(w);     chk("R6 ipi vector", w, 32'hff00_0002);
    peek(2'd1, w); chk("R4 threshold after ipi", w, 32'h03);
    peek(2'd2, w); chk("R8 accept keeps ipi prio", w, 32'h03);
    wr(2'd0, 32'hff00_0002);
    chk("R9 more after ipi eoi", 32'(eoi_more), 32'd1);
    peek(2'd2, w); chk("R8 eoi keeps ipi prio", w, 32'h03);
    chk("R6 ipi presented again", 32'(cpu_irq), 32'd1);
    wr(2'd2, 32'hff);
    chk("R6 ipi cancelled", 32'(cpu_irq), 32'd0);
    accept(w);     chk("R6 nothing after cancel", w, 32'hff00_0000);
  endtask

  task automatic t_arb;
    wr(2'd2, 32'h04);
    push(24'h0000aa, 8'd4);
    accept(w);     chk("R7 tie goes to ipi", w, 32'hff00_0002);
    wr(2'd0, 32'hff00_0002);
    chk("R9 more with both pending", 32'(eoi_more), 32'd1);
    wr(2'd2, 32'h06);
    accept(w);     chk("R7 lower external wins", w, 32'hff00_00aa);
    wr(2'd2, 32'hff);
    wr(2'd0, 32'hff00_00aa);
    chk("R9 no more when empty", 32'(eoi_more), 32'd0);
    push(24'h000077, 8'd7);
    wr(2'd0, 32'h0700_0000);
    chk("R9 equal priority not more", 32'(eoi_more), 32'd0);
    chk("R1 equal not presented", 32'(cpu_irq), 32'd0);
    wr(2'd0, 32'h0800_0000);
    chk("R9 more above pending", 32'(eoi_more), 32'd1);
    @(negedge clk);
    chk("R9 more is a pulse", 32'(eoi_more), 32'd0);
  endtask

  task automatic t_slot;
    push(24'h000088, 8'd1);
    wr(2'd1, 32'hff);
    accept(w);     chk("R10 full slot ignores new", w, 32'hff00_0077);
    wr(2'd1, 32'hff);
    push(24'h000000, 8'd1);
    chk("R10 vector 0 dropped", 32'(cpu_irq), 32'd0);
    push(24'h000002, 8'd1);
    chk("R10 vector 2 dropped", 32'(cpu_irq), 32'd0);
    push(24'h000099, 8'd1);
    chk("R10 empty slot latches", 32'(cpu_irq), 32'd1);
    accept(w);     chk("R10 latched vector", w, 32'hff00_0099);
  endtask

  task automatic t_regmap;
    wr(2'd1, 32'h1234_56ab);
    peek(2'd1, w); chk("R3 threshold low byte", w, 32'h0000_00ab);
    wr(2'd3, 32'hffff_ffff);
    peek(2'd1, w); chk("R3 select 3 write ignored", w, 32'h0000_00ab);
    peek(2'd2, w); chk("R3 select 3 leaves ipi", w, 32'h0000_00ff);
    peek(2'd3, w); chk("R3 select 3 reads zero", w, 32'h0);
    @(negedge clk); reg_sel = 2'd1; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    peek(2'd1, w); chk("R3 read has no effect", w, 32'h0000_00ab);
    wr(2'd0, 32'h3cff_ffff);
    peek(2'd0, w); chk("R3 eoi uses top byte", w, 32'h3c00_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_threshold();
    t_ipi();
    t_arb();
    t_slot();
    t_regmap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule